// File: doc/BRIEF.md
# Block-Write Configuration Register Target

This block is an I2C target that holds a bank of six 8-bit configuration registers. The registers drive the rest of the chip through a flat parallel bus. A host writes them with one fixed frame. The frame carries the write address, a command byte, a byte-count byte and then data. The command and count bytes are acknowledged and thrown away. Data always fills the bank from register 0 upward, one register per byte, until the host sends STOP.

A read frame on the read address returns a byte that holds the bank size. The register contents follow, lowest register first, most significant bit first. SCL and SDA are sampled by the system clock, which must run at least 16 times faster than the bit rate, and each line passes through a two-flop synchronizer. SDA is open-drain. It is modelled as the sampled line plus an enable that pulls the line low. The target never stretches the clock.

Top module: `cfg_i2c_target`

## Requirements
- R1: After reset the register bus shows the defaults: register 0 = 0xE7, 1 = 0x81, 2 = 0x3F, 3 = 0x5A, 4 = 0x9C, 5 = 0x00. Register n sits at bits 8n+7..8n of `cfg_o`, and `sda_oe_o` is low.
- R2: The 8-bit address byte 0xD2 (write) and 0xD3 (read) are acknowledged. The target pulls SDA low for the ninth clock. Any other address gets no acknowledge, and the target leaves SDA alone until the next START.
- R3: In a write, the two bytes after the address (command and count) are each acknowledged and change no register.
- R4: The data bytes that follow go to registers 0, 1, 2 … in order, MSB first, and each one is acknowledged.
- R5: A STOP after any complete data byte keeps the registers already written and leaves the rest at their earlier values.
- R6: Data bytes beyond register 5 are acknowledged but change no register.
- R7: A register changes only when its complete byte has been received. A byte cut short by STOP writes nothing.
- R8: A read returns 0x06 first, then registers 0 through 5. Each byte is sent MSB first and is followed by a host acknowledge slot.
- R9: If the host does not acknowledge a read byte, the target releases SDA and drives nothing until the next START.
- R10: A START (SDA falling while SCL is high) at any point restarts address reception. SDA changes while SCL is low are data, not conditions.
- R11: On a STOP (SDA rising while SCL is high) the target releases SDA and returns to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 16x the bit rate |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Sampled SCL line |
| sda_i | input | 1 | Sampled SDA line |
| sda_oe_o | output | 1 | 1 pulls SDA low, 0 releases it |
| cfg_o | output | 48 | Register bank, register n at bits 8n+7..8n |

## Verification
The target moves SDA three system clocks after an SCL edge reaches its pins: two synchronizer stages plus the sequencer register. The bench therefore samples SDA and the acknowledge enable eight clocks into each SCL high phase, well clear of that delay. A register takes its new value four clocks after the SCL fall that ends its eighth bit. The behavioural model updates its copy sixteen clocks after that fall. The per-clock comparison of the whole bus pauses only between those two points, so any early, late, partial or extra write shows up as a miscompare on some clock.

// File: rtl/cfg_i2c_pkg.sv
// Shared types for the configuration target.
// Assumes: the byte width on the bus is always eight bits.
package cfg_i2c_pkg;

    localparam int unsigned BYTE_W = 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_WDATA,
        ST_WACK,
        ST_RDATA,
        ST_RACK,
        ST_WAIT
    } i2c_st_e;

endpackage

// File: rtl/cfg_i2c_cond.sv
// Bus conditioner: synchronizes SCL/SDA to clk and flags SCL edges,
// START and STOP as one-cycle pulses.
// Assumes: clk is at least 16x the bit rate and idle lines are high.
module cfg_i2c_cond (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_s_o,
    output logic scl_rise_o,
    output logic scl_fall_o,
    output logic start_o,
    output logic stop_o
);

    logic scl_q1, scl_q2, scl_d;
    logic sda_q1, sda_q2, sda_d;

    // two-flop synchronizers plus one delayed copy for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_q1 <= 1'b1; scl_q2 <= 1'b1; scl_d <= 1'b1;
            sda_q1 <= 1'b1; sda_q2 <= 1'b1; sda_d <= 1'b1;
        end else begin
            scl_q1 <= scl_i; scl_q2 <= scl_q1; scl_d <= scl_q2;
            sda_q1 <= sda_i; sda_q2 <= sda_q1; sda_d <= sda_q2;
        end
    end

    assign sda_s_o    = sda_q2;
    assign scl_rise_o = scl_q2 & ~scl_d;
    assign scl_fall_o = ~scl_q2 & scl_d;
    assign start_o    = scl_q2 & scl_d & sda_d & ~sda_q2;
    assign stop_o     = scl_q2 & scl_d & ~sda_d & sda_q2;

endmodule

// File: rtl/cfg_i2c_fsm.sv
// Protocol sequencer: receives address and write bytes, sends read
// bytes, drives the acknowledge, and issues one write strobe per
// complete data byte.
// Assumes: inputs come from cfg_i2c_cond; no clock stretching.
module cfg_i2c_fsm
    import cfg_i2c_pkg::*;
#(
    parameter int unsigned NUM_REGS = 6,
    parameter logic [6:0]  DEV_ADDR = 7'h69,
    localparam int unsigned IDX_W   = $clog2(NUM_REGS),
    localparam int unsigned PTR_W   = $clog2(NUM_REGS + 1),
    localparam int unsigned BIDX_W  = $clog2(NUM_REGS + 3)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sda_s,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_det,
    input  logic              stop_det,
    input  logic [BYTE_W-1:0] rd_data,
    output logic [PTR_W-1:0]  rd_idx,
    output logic              wr_en,
    output logic [IDX_W-1:0]  wr_idx,
    output logic [BYTE_W-1:0] wr_data,
    output logic              sda_oe
);

    localparam logic [BIDX_W-1:0] BIDX_FIRST = BIDX_W'(2);
    localparam logic [BIDX_W-1:0] BIDX_LIMIT = BIDX_W'(NUM_REGS + 2);

    i2c_st_e             state;
    logic [3:0]          bitcnt;
    logic [BYTE_W-1:0]   shreg;
    logic [BYTE_W-1:0]   txsh;
    logic [BIDX_W-1:0]   byte_idx;
    logic [PTR_W-1:0]    rd_ptr;
    logic                is_read;
    logic                host_ack;

    assign rd_idx = rd_ptr;

    // frame sequencing, shifting and acknowledge control
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            bitcnt   <= '0;
            shreg    <= '0;
            txsh     <= '0;
            byte_idx <= '0;
            rd_ptr   <= '0;
            is_read  <= 1'b0;
            host_ack <= 1'b0;
            sda_oe   <= 1'b0;
            wr_en    <= 1'b0;
            wr_idx   <= '0;
            wr_data  <= '0;
        end else begin
            wr_en <= 1'b0;
            if (start_det) begin
                state  <= ST_ADDR;
                bitcnt <= '0;
                sda_oe <= 1'b0;
            end else if (stop_det) begin
                state  <= ST_IDLE;
                sda_oe <= 1'b0;
            end else begin
                case (state)
                    ST_ADDR, ST_WDATA: begin
                        if (scl_rise) begin
                            shreg  <= {shreg[BYTE_W-2:0], sda_s};
                            bitcnt <= bitcnt + 4'd1;
                        end else if (scl_fall && bitcnt == 4'd8) begin
                            if (state == ST_ADDR) begin
                                if (shreg[7:1] == DEV_ADDR) begin
                                    sda_oe  <= 1'b1;
                                    is_read <= shreg[0];
                                    state   <= ST_ADDR_ACK;
                                end else begin
                                    state <= ST_WAIT;
                                end
                            end else begin
                                sda_oe <= 1'b1;
                                state  <= ST_WACK;
                                if (byte_idx >= BIDX_FIRST && byte_idx < BIDX_LIMIT) begin
                                    wr_en   <= 1'b1;
                                    wr_idx  <= IDX_W'(byte_idx - BIDX_FIRST);
                                    wr_data <= shreg;
                                end
                                if (byte_idx != BIDX_LIMIT)
                                    byte_idx <= byte_idx + BIDX_W'(1);
                            end
                        end
                    end
                    ST_ADDR_ACK: begin
                        if (scl_fall) begin
                            bitcnt <= '0;
                            if (is_read) begin
                                txsh   <= BYTE_W'(NUM_REGS);
                                sda_oe <= ~BYTE_W'(NUM_REGS) >> (BYTE_W - 1) == 1'b1;
                                rd_ptr <= '0;
                                state  <= ST_RDATA;
                            end else begin
                                sda_oe   <= 1'b0;
                                byte_idx <= '0;
                                state    <= ST_WDATA;
                            end
                        end
                    end
                    ST_WACK: begin
                        if (scl_fall) begin
                            sda_oe <= 1'b0;
                            bitcnt <= '0;
                            state  <= ST_WDATA;
                        end
                    end
                    ST_RDATA: begin
                        if (scl_fall) begin
                            if (bitcnt == 4'd7) begin
                                sda_oe <= 1'b0;
                                bitcnt <= '0;
                                state  <= ST_RACK;
                            end else begin
                                txsh   <= {txsh[BYTE_W-2:0], 1'b0};
                                sda_oe <= ~txsh[BYTE_W-2];
                                bitcnt <= bitcnt + 4'd1;
                            end
                        end
                    end
                    ST_RACK: begin
                        if (scl_rise) begin
                            host_ack <= ~sda_s;
                        end else if (scl_fall) begin
                            if (host_ack && rd_ptr < PTR_W'(NUM_REGS)) begin
                                txsh   <= rd_data;
                                sda_oe <= ~rd_data[BYTE_W-1];
                                rd_ptr <= rd_ptr + PTR_W'(1);
                                bitcnt <= '0;
                                state  <= ST_RDATA;
                            end else begin
                                state <= ST_WAIT;
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    // R2 / R9: SDA is only pulled while an acknowledge or read bit is owed
    assert_drive_owned_R9: assert property (@(posedge clk) disable iff (!rst_n)
        sda_oe |-> (state inside {ST_ADDR_ACK, ST_WACK, ST_RDATA}));

    // R11: a STOP leaves the target idle with SDA released
    assert_release_on_stop_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_det && !start_det) |=> (state == ST_IDLE && !sda_oe));

    // R7: a register write follows the SCL fall that ends a byte
    assert_write_at_byte_end_R7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> ($past(scl_fall) && state == ST_WACK));

    // R10: START always reopens address reception
    assert_start_restarts_R10: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> (state == ST_ADDR && bitcnt == 4'd0));

endmodule

// File: rtl/cfg_reg_bank.sv
// Register bank: NUM_REGS bytes with power-on defaults, one write
// port and a combinational read port for the sequencer.
// Assumes: wr_idx is below NUM_REGS whenever wr_en is high.
module cfg_reg_bank
    import cfg_i2c_pkg::*;
#(
    parameter int unsigned NUM_REGS = 6,
    parameter logic [NUM_REGS*BYTE_W-1:0] DEFAULTS = '0,
    localparam int unsigned IDX_W = $clog2(NUM_REGS),
    localparam int unsigned PTR_W = $clog2(NUM_REGS + 1)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  logic [IDX_W-1:0]           wr_idx,
    input  logic [BYTE_W-1:0]          wr_data,
    input  logic [PTR_W-1:0]           rd_idx,
    output logic [BYTE_W-1:0]          rd_data,
    output logic [NUM_REGS*BYTE_W-1:0] regs_o
);

    logic [BYTE_W-1:0] regs [NUM_REGS];

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
        // one storage byte, loaded from DEFAULTS on reset
        always_ff @(posedge clk) begin
            if (!rst_n)
                regs[g] <= DEFAULTS[g*BYTE_W +: BYTE_W];
            else if (wr_en && wr_idx == IDX_W'(g))
                regs[g] <= wr_data;
        end
        assign regs_o[g*BYTE_W +: BYTE_W] = regs[g];
    end

    // read mux for the serializer, zero past the last register
    always_comb begin
        rd_data = '0;
        if (rd_idx < PTR_W'(NUM_REGS))
            rd_data = regs[rd_idx[IDX_W-1:0]];
    end

    // R7: the bank holds its value on every cycle without a write strobe
    assert_hold_without_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(regs_o));

    // R6: strobes never address a register past the bank
    assert_index_in_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (wr_idx < IDX_W'(NUM_REGS)));

endmodule

// File: rtl/cfg_i2c_target.sv
// Top level: I2C block-write configuration target with a parallel
// register bus output.
// Assumes: open-drain SDA outside the block; clk >= 16x bit rate.
module cfg_i2c_target
    import cfg_i2c_pkg::*;
#(
    parameter int unsigned NUM_REGS = 6,
    parameter logic [6:0]  DEV_ADDR = 7'h69,
    parameter logic [NUM_REGS*BYTE_W-1:0] DEFAULTS = 48'h00_9C_5A_3F_81_E7,
    localparam int unsigned IDX_W = $clog2(NUM_REGS),
    localparam int unsigned PTR_W = $clog2(NUM_REGS + 1)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       scl_i,
    input  logic                       sda_i,
    output logic                       sda_oe_o,
    output logic [NUM_REGS*BYTE_W-1:0] cfg_o
);

    logic              sda_s, scl_rise, scl_fall, start_det, stop_det;
    logic              wr_en;
    logic [IDX_W-1:0]  wr_idx;
    logic [BYTE_W-1:0] wr_data, rd_data;
    logic [PTR_W-1:0]  rd_idx;

    cfg_i2c_cond u_cond (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (scl_i),
        .sda_i      (sda_i),
        .sda_s_o    (sda_s),
        .scl_rise_o (scl_rise),
        .scl_fall_o (scl_fall),
        .start_o    (start_det),
        .stop_o     (stop_det)
    );

    cfg_i2c_fsm #(
        .NUM_REGS (NUM_REGS),
        .DEV_ADDR (DEV_ADDR)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det),
        .rd_data   (rd_data),
        .rd_idx    (rd_idx),
        .wr_en     (wr_en),
        .wr_idx    (wr_idx),
        .wr_data   (wr_data),
        .sda_oe    (sda_oe_o)
    );

    cfg_reg_bank #(
        .NUM_REGS (NUM_REGS),
        .DEFAULTS (DEFAULTS)
    ) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_idx  (wr_idx),
        .wr_data (wr_data),
        .rd_idx  (rd_idx),
        .rd_data (rd_data),
        .regs_o  (cfg_o)
    );

endmodule

// File: tb/cfg_i2c_target_tb.sv
// Bench: host-side bit-banged frames with a behavioural register model
// compared against the bus on every clock.
module cfg_i2c_target_tb;

    localparam int CLK_PERIOD = 10;
    localparam int H = 16;
    localparam int Q = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_scl = 1'b1;
    logic        host_sda = 1'b1;
    logic        sda_oe;
    logic [47:0] cfg;
    wire         sda_line = host_sda & ~sda_oe;

    int vectors = 0;
    int miscompares = 0;
    bit hold = 1'b1;
    bit done = 1'b0;
    logic [7:0] exp_reg [6];

    always #(CLK_PERIOD/2) clk = ~clk;

    cfg_i2c_target u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_i    (host_scl),
        .sda_i    (sda_line),
        .sda_oe_o (sda_oe),
        .cfg_o    (cfg)
    );

    function automatic logic [47:0] exp_flat();
        logic [47:0] v;
        for (int i = 0; i < 6; i++) v[i*8 +: 8] = exp_reg[i];
        return v;
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [47:0] act, input logic [47:0] expv);
        vectors++;
        if (!ok) begin
            miscompares++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
        end
    endtask

    // R7 / R5 / R6: bus matches the model on every settled clock
    always @(negedge clk) begin
        if (rst_n && !hold && !done) chk(cfg === exp_flat(), "R7 register bus vs model", cfg, exp_flat());
    end

    task automatic wait_clks(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_start();
        host_sda = 1'b1; wait_clks(Q);
        host_scl = 1'b1; wait_clks(Q);
        host_sda = 1'b0; wait_clks(H);
        host_scl = 1'b0; wait_clks(Q);
    endtask

    task automatic do_stop();
        host_sda = 1'b0; wait_clks(Q);
        host_scl = 1'b1; wait_clks(H);
        host_sda = 1'b1; wait_clks(H);
        chk(sda_oe == 1'b0, "R11 SDA released after STOP", 48'(sda_oe), 48'd0);
    endtask

    // send the top n bits of b; optional model update at the byte end
    task automatic send_bits(input logic [7:0] b, input int n, input bit upd, input int idx);
        for (int i = 7; i > 7 - n; i--) begin
            host_sda = b[i]; wait_clks(Q);
            host_scl = 1'b1; wait_clks(H);
            if (upd && i == 0) hold = 1'b1;
            host_scl = 1'b0; wait_clks(Q);
        end
        if (upd) begin
            wait_clks(Q);
            exp_reg[idx] = b;
            hold = 1'b0;
        end
    endtask

    task automatic ack_slot(input bit expect_ack, input string tag);
        host_sda = 1'b1; wait_clks(Q);
        host_scl = 1'b1; wait_clks(H/2);
        chk(sda_oe == expect_ack, tag, 48'(sda_oe), 48'(expect_ack));
        wait_clks(H/2);
        host_scl = 1'b0; wait_clks(Q);
    endtask

    task automatic recv_byte(input logic [7:0] expv, input bit give_ack, input string tag);
        logic [7:0] got;
        host_sda = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            wait_clks(Q);
            host_scl = 1'b1; wait_clks(H/2);
            got[i] = sda_line;
            wait_clks(H/2);
            host_scl = 1'b0;
        end
        chk(got == expv, tag, 48'(got), 48'(expv));
        wait_clks(Q);
        host_sda = ~give_ack; wait_clks(Q);
        host_scl = 1'b1; wait_clks(H);
        host_scl = 1'b0; wait_clks(Q);
        host_sda = 1'b1;
    endtask

    task automatic write_frame(input logic [7:0] data [], input int nbytes);
        do_start();
        send_bits(8'hD2, 8, 1'b0, 0);
        ack_slot(1'b1, "R2 write address acknowledged");
        send_bits(8'hA5, 8, 1'b0, 0);
        ack_slot(1'b1, "R3 command byte acknowledged");
        send_bits(8'h3C, 8, 1'b0, 0);
        ack_slot(1'b1, "R3 count byte acknowledged");
        chk(cfg === exp_flat(), "R3 command/count leave registers", cfg, exp_flat());
        for (int k = 0; k < nbytes; k++) begin
            send_bits(data[k], 8, k < 6, k);
            ack_slot(1'b1, k < 6 ? "R4 data byte acknowledged" : "R6 extra byte acknowledged");
        end
        do_stop();
    endtask

    task automatic read_frame();
        do_start();
        send_bits(8'hD3, 8, 1'b0, 0);
        ack_slot(1'b1, "R2 read address acknowledged");
        recv_byte(8'h06, 1'b1, "R8 byte count");
        for (int k = 0; k < 6; k++) recv_byte(exp_reg[k], 1'b1, "R8 register byte");
        do_stop();
    endtask

    initial begin
        logic [7:0] d [];
        exp_reg[0] = 8'hE7; exp_reg[1] = 8'h81; exp_reg[2] = 8'h3F;
        exp_reg[3] = 8'h5A; exp_reg[4] = 8'h9C; exp_reg[5] = 8'h00;
        wait_clks(5);
        rst_n = 1'b1;
        wait_clks(2);
        chk(cfg === exp_flat(), "R1 reset defaults", cfg, exp_flat());
        chk(sda_oe == 1'b0, "R1 SDA released at reset", 48'(sda_oe), 48'd0);
        hold = 1'b0;

        // R4: full block write
        d = new[6];
        d[0] = 8'h11; d[1] = 8'h22; d[2] = 8'h93; d[3] = 8'h44; d[4] = 8'hC5; d[5] = 8'h6E;
        write_frame(d, 6);
        chk(cfg === 48'h6E_C5_44_93_22_11, "R4 ascending fill", cfg, 48'h6E_C5_44_93_22_11);

        // R8: read back
        read_frame();

        // R5: stop after two data bytes
        d = new[2];
        d[0] = 8'hF0; d[1] = 8'h0F;
        write_frame(d, 2);
        chk(cfg === 48'h6E_C5_44_93_0F_F0, "R5 partial write keeps rest", cfg, 48'h6E_C5_44_93_0F_F0);

        // R6: eight data bytes, last two discarded
        d = new[8];
        for (int k = 0; k < 8; k++) d[k] = 8'(8'h30 + k);
        write_frame(d, 8);
        chk(cfg === 48'h35_34_33_32_31_30, "R6 overflow bytes dropped", cfg, 48'h35_34_33_32_31_30);

        // R7: one full byte then a half byte cut by STOP
        do_start();
        send_bits(8'hD2, 8, 1'b0, 0); ack_slot(1'b1, "R2 write address acknowledged");
        send_bits(8'h00, 8, 1'b0, 0); ack_slot(1'b1, "R3 command byte acknowledged");
        send_bits(8'h00, 8, 1'b0, 0); ack_slot(1'b1, "R3 count byte acknowledged");
        send_bits(8'hAB, 8, 1'b1, 0); ack_slot(1'b1, "R4 data byte acknowledged");
        send_bits(8'hFF, 4, 1'b0, 0);
        do_stop();
        chk(cfg === 48'h35_34_33_32_31_AB, "R7 half byte writes nothing", cfg, 48'h35_34_33_32_31_AB);

        // R2: foreign addresses ignored
        do_start();
        send_bits(8'hA4, 8, 1'b0, 0); ack_slot(1'b0, "R2 foreign address not acknowledged");
        send_bits(8'h5D, 8, 1'b0, 0); ack_slot(1'b0, "R2 no drive after foreign address");
        do_stop();
        do_start();
        send_bits(8'hD6, 8, 1'b0, 0); ack_slot(1'b0, "R2 near address not acknowledged");
        do_stop();
        chk(cfg === exp_flat(), "R2 registers untouched", cfg, exp_flat());

        // R9: host NACK ends the read
        do_start();
        send_bits(8'hD3, 8, 1'b0, 0); ack_slot(1'b1, "R2 read address acknowledged");
        recv_byte(8'h06, 1'b1, "R8 byte count");
        recv_byte(exp_reg[0], 1'b0, "R9 byte before NACK");
        for (int k = 0; k < 9; k++) ack_slot(1'b0, "R9 released after NACK");
        do_stop();

        // R10: START mid-address restarts reception
        do_start();
        send_bits(8'hD2, 3, 1'b0, 0);
        do_start();
        send_bits(8'hD3, 8, 1'b0, 0); ack_slot(1'b1, "R10 restarted address acknowledged");
        recv_byte(8'h06, 1'b1, "R10 count after restart");
        recv_byte(exp_reg[0], 1'b0, "R10 first register after restart");
        do_stop();

        read_frame();

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            miscompares++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

endmodule